// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block sequences the power modes of a battery-backed microcontroller system. It keeps one of four modes: mission (main supply present, processor running), brownout (battery only, processor running), sleep (processor halted, digital supply switched off, only the battery domain alive), and a waking phase. In the waking phase the digital supply is closed again and the processor is held in reset so that it restarts from address zero. The real-time clock, oscillator, temperature sensing and analog supply switching sit outside. The block sees them only as status inputs and drives them only through control outputs.

Software asks for sleep by writing a one to the request bit of a control register. The request clears itself as sleep is entered, so a stale request cannot send the system straight back to sleep. Sleep ends only when main power returns or a wake event arrives. A request made while main power is present therefore passes through sleep for a single cycle, drops the wake signal, and then runs the normal wake sequence. Each wake flags the volatile RAM as undefined and pulses a clear for the volatile register sections. When the external reset input is high as sleep ends, it also pulses a clear for the non-volatile sections.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, `mode` is 3 (waking), `cpu_rst`, `vdd_sw_en`, `wake` and `xram_invalid` are 1, and `sleep_pending`, `vol_clr` and `nv_clr` are 0.
- R2: A write (`wr_en`=1) to address `SLEEP_ADDR` (default 16'h28B2) while `mode` is 0 or 1 loads `wr_data` bit `SLEEP_BIT` (default 7) into `sleep_pending` at the next edge. A write to any other address leaves `sleep_pending` unchanged. A write while `mode` is 2 or 3 is ignored.
- R3: When `sleep_pending` is 1 in mode 0 or 1, the next cycle has `mode`=2 and `sleep_pending`=0. This takes priority over any power-change transition or write in that cycle. In mode 2, `vdd_sw_en`=0, `wake`=0 and `cpu_rst`=1.
- R4: In mode 2, with `main_pwr_ok`=0 and every `wake_evt` bit 0, the block stays in mode 2.
- R5: In mode 2, `main_pwr_ok`=1 or any `wake_evt` bit 1 makes the next cycle mode 3. A sleep request made with main power present therefore spends exactly one cycle in mode 2.
- R6: Mode 3 lasts exactly `RST_CYCLES` cycles (default 8). During it, `vdd_sw_en`=1, `wake`=1 and `cpu_rst`=1. `cpu_rst` is 0 in modes 0 and 1, and it never falls unless `vdd_sw_en` was 1 in the cycle before.
- R7: After the last cycle of mode 3, the mode becomes 0 if `main_pwr_ok` was 1 in that last cycle, and 1 otherwise.
- R8: Without a pending sleep request, mode 0 goes to mode 1 when `main_pwr_ok` is 0, and mode 1 goes to mode 0 when it is 1.
- R9: `vol_clr` is a one-cycle pulse in the first mode-3 cycle after mode 2. `nv_clr` pulses in that same cycle only if `ext_reset` was 1 in the last mode-2 cycle.
- R10: `xram_invalid` becomes 1 in the first mode-3 cycle after mode 2. It becomes 0 the cycle after a write that R2 accepts, whatever the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_pwr_ok | input | 1 | Main supply present |
| wake_evt | input | N_WAKE | Wake event requests, any bit wakes |
| ext_reset | input | 1 | External reset pin level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| mode | output | 2 | 0 mission, 1 brownout, 2 sleep, 3 waking |
| vdd_sw_en | output | 1 | Digital supply switch closed |
| cpu_rst | output | 1 | Processor reset, restart at address zero |
| wake | output | 1 | Internal wake signal |
| sleep_pending | output | 1 | Sleep request bit |
| xram_invalid | output | 1 | Volatile RAM contents undefined |
| vol_clr | output | 1 | Clear pulse for volatile register sections |
| nv_clr | output | 1 | Clear pulse for non-volatile register sections |

## Verification
The assertions assume that `wake_evt`, `main_pwr_ok` and `ext_reset` are already synchronous to `clk` in the default configuration, and that register writes come only from a running processor, so a write seen during sleep or waking is stray. The random stimulus changes every input only between edges. It flips main power rarely so that both wake targets and long brownout sleeps occur, and it aims about half of its writes at the control address so that requests, clears and ignored writes all appear. Directed sequences force the single-cycle sleep under main power, a long sleep on battery, and a wake with the external reset high.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
   typedef enum logic [1:0] {
      MODE_MISSION  = 2'd0,
      MODE_BROWNOUT = 2'd1,
      MODE_SLEEP    = 2'd2,
      MODE_WAKING   = 2'd3
   } pmode_e;

   function automatic logic cpu_running(pmode_e m);
      return (m == MODE_MISSION) || (m == MODE_BROWNOUT);
   endfunction
endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] SLEEP_ADDR = 16'h28B2,
   parameter int SLEEP_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cpu_run,
   input  logic              sleep_take,
   input  logic              wake_start,
   output logic              sleep_pending,
   output logic              xram_invalid
);
   logic wr_hit;
   assign wr_hit = wr_en && cpu_run && (wr_addr == SLEEP_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sleep_pending <= 1'b0;
      else if (sleep_take) sleep_pending <= 1'b0;
      else if (wr_hit)     sleep_pending <= wr_data[SLEEP_BIT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          xram_invalid <= 1'b1;
      else if (wake_start) xram_invalid <= 1'b1;
      else if (wr_hit)     xram_invalid <= 1'b0;
   end

   assert_req_selfclear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_take |=> !sleep_pending);
   assert_req_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !sleep_take) |=> (sleep_pending == $past(wr_data[SLEEP_BIT])));
   assert_req_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_run && !sleep_take) |=> $stable(sleep_pending));
   assert_xram_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wake_start |=> xram_invalid);
endmodule

// File: rtl/pmc_settle_cnt.sv
module pmc_settle_cnt #(
   parameter int RST_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int CW = $clog2(RST_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   assign done = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (run && !done) cnt_q <= cnt_q + 1'b1;
      else                   cnt_q <= '0;
   end

   assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
   assert_cnt_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0));
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
   import pwr_mode_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   main_ok,
   input  logic   wake_hit,
   input  logic   ext_reset,
   input  logic   sleep_pending,
   input  logic   settle_done,
   output pmode_e mode,
   output logic   sleep_take,
   output logic   wake_start,
   output logic   vol_clr,
   output logic   nv_clr
);
   pmode_e state_q, state_d;

   assign mode       = state_q;
   assign sleep_take = cpu_running(state_q) && sleep_pending;
   assign wake_start = (state_q == MODE_SLEEP) && (main_ok || wake_hit);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         MODE_MISSION: begin
            if (sleep_pending) state_d = MODE_SLEEP;
            else if (!main_ok) state_d = MODE_BROWNOUT;
         end
         MODE_BROWNOUT: begin
            if (sleep_pending) state_d = MODE_SLEEP;
            else if (main_ok)  state_d = MODE_MISSION;
         end
         MODE_SLEEP: begin
            if (wake_start) state_d = MODE_WAKING;
         end
         MODE_WAKING: begin
            if (settle_done) state_d = main_ok ? MODE_MISSION : MODE_BROWNOUT;
         end
         default: state_d = MODE_WAKING;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MODE_WAKING;
         vol_clr <= 1'b0;
         nv_clr  <= 1'b0;
      end else begin
         state_q <= state_d;
         vol_clr <= wake_start;
         nv_clr  <= wake_start && ext_reset;
      end
   end

   assert_sleep_prio_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_take |=> (state_q == MODE_SLEEP));
   assert_stay_asleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MODE_SLEEP && !main_ok && !wake_hit) |=> (state_q == MODE_SLEEP));
   assert_wake_begin_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MODE_SLEEP && (main_ok || wake_hit)) |=> (state_q == MODE_WAKING));
   assert_waking_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MODE_WAKING && !settle_done) |=> (state_q == MODE_WAKING));
   assert_exit_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MODE_WAKING && settle_done) |=>
         (state_q == ($past(main_ok) ? MODE_MISSION : MODE_BROWNOUT)));
   assert_nv_with_vol_R9: assert property (@(posedge clk) disable iff (!rst_n)
      nv_clr |-> vol_clr);
   assert_vol_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      vol_clr |-> (state_q == MODE_WAKING) && !$past(vol_clr));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pwr_mode_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] SLEEP_ADDR = 16'h28B2,
   parameter int SLEEP_BIT  = 7,
   parameter int N_WAKE     = 4,
   parameter int RST_CYCLES = 8,
   parameter bit WAKE_SYNC  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              main_pwr_ok,
   input  logic [N_WAKE-1:0] wake_evt,
   input  logic              ext_reset,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [1:0]        mode,
   output logic              vdd_sw_en,
   output logic              cpu_rst,
   output logic              wake,
   output logic              sleep_pending,
   output logic              xram_invalid,
   output logic              vol_clr,
   output logic              nv_clr
);
   if (SLEEP_BIT < 0 || SLEEP_BIT >= DATA_W) begin : g_bad_bit
      $error("SLEEP_BIT outside data word");
   end
   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("RST_CYCLES must be at least 1");
   end
   if (N_WAKE < 1) begin : g_bad_wake
      $error("N_WAKE must be at least 1");
   end

   logic   wake_hit, sleep_take, wake_start, settle_done;
   pmode_e mode_e;

   if (WAKE_SYNC) begin : g_wake_sync
      logic wake_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) wake_q <= 1'b0;
         else        wake_q <= |wake_evt;
      end
      assign wake_hit = wake_q;
   end else begin : g_wake_direct
      assign wake_hit = |wake_evt;
   end

   pmc_ctrl_reg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .SLEEP_ADDR(SLEEP_ADDR), .SLEEP_BIT(SLEEP_BIT)
   ) u_reg (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cpu_run(cpu_running(mode_e)),
      .sleep_take(sleep_take), .wake_start(wake_start),
      .sleep_pending(sleep_pending), .xram_invalid(xram_invalid)
   );

   pmc_settle_cnt #(.RST_CYCLES(RST_CYCLES)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .run(mode_e == MODE_WAKING),
      .done(settle_done)
   );

   pmc_fsm u_fsm (
      .clk(clk), .rst_n(rst_n),
      .main_ok(main_pwr_ok), .wake_hit(wake_hit), .ext_reset(ext_reset),
      .sleep_pending(sleep_pending), .settle_done(settle_done),
      .mode(mode_e), .sleep_take(sleep_take), .wake_start(wake_start),
      .vol_clr(vol_clr), .nv_clr(nv_clr)
   );

   assign mode      = mode_e;
   assign vdd_sw_en = (mode_e != MODE_SLEEP);
   assign wake      = (mode_e != MODE_SLEEP);
   assign cpu_rst   = !cpu_running(mode_e);

   assert_rst_after_supply_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_rst) |-> $past(vdd_sw_en));
   assert_sleep_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_e == MODE_SLEEP) |-> !vdd_sw_en && !wake && cpu_rst && !sleep_pending);
endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;
   localparam int RSTC = 8;
   localparam logic [15:0] SADDR = 16'h28B2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic main_pwr_ok = 1'b1;
   logic [3:0] wake_evt = '0;
   logic ext_reset = 1'b0;
   logic wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] mode;
   logic vdd_sw_en, cpu_rst, wake, sleep_pending, xram_invalid, vol_clr, nv_clr;

   int n_chk = 0, n_fail = 0;
   bit done_flag = 0;
   int m_mode, m_cnt;
   bit m_pend, m_xinv, m_vclr, m_nclr;

   pwr_mode_ctrl #(.RST_CYCLES(RSTC)) dut_i (
      .clk(clk), .rst_n(rst_n), .main_pwr_ok(main_pwr_ok), .wake_evt(wake_evt),
      .ext_reset(ext_reset), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .mode(mode), .vdd_sw_en(vdd_sw_en), .cpu_rst(cpu_rst), .wake(wake),
      .sleep_pending(sleep_pending), .xram_invalid(xram_invalid),
      .vol_clr(vol_clr), .nv_clr(nv_clr));

   always #4 clk = ~clk;

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit run_mode(int m);
      return (m == 0) || (m == 1);
   endfunction

   task automatic check_all();
      chk("R8 mode", int'(mode), m_mode);
      chk("R2 sleep_pending", int'(sleep_pending), int'(m_pend));
      chk("R6 vdd_sw_en", int'(vdd_sw_en), int'(m_mode != 2));
      chk("R6 wake", int'(wake), int'(m_mode != 2));
      chk("R6 cpu_rst", int'(cpu_rst), int'(!run_mode(m_mode)));
      chk("R10 xram_invalid", int'(xram_invalid), int'(m_xinv));
      chk("R9 vol_clr", int'(vol_clr), int'(m_vclr));
      chk("R9 nv_clr", int'(nv_clr), int'(m_nclr));
   endtask

   // one clock: inputs already driven; compute model, clock, compare at negedge
   task automatic step();
      bit hit, take, wexit, cdone;
      int nm;
      hit   = wr_en && run_mode(m_mode) && (wr_addr == SADDR);
      take  = run_mode(m_mode) && m_pend;
      wexit = (m_mode == 2) && (main_pwr_ok || (|wake_evt));
      cdone = (m_mode == 3) && (m_cnt == RSTC - 1);
      nm = m_mode;
      case (m_mode)
         0: nm = m_pend ? 2 : (!main_pwr_ok ? 1 : 0);
         1: nm = m_pend ? 2 : (main_pwr_ok ? 0 : 1);
         2: nm = wexit ? 3 : 2;
         default: nm = cdone ? (main_pwr_ok ? 0 : 1) : 3;
      endcase
      @(posedge clk);
      m_cnt  = ((m_mode == 3) && !cdone) ? m_cnt + 1 : 0;
      if (take) m_pend = 0;
      else if (hit) m_pend = wr_data[7];
      if (wexit) m_xinv = 1;
      else if (hit) m_xinv = 0;
      m_vclr = wexit;
      m_nclr = wexit && ext_reset;
      m_mode = nm;
      @(negedge clk);
      check_all();
   endtask

   task automatic quiet();
      wr_en = 0; wake_evt = '0;
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      if (!done_flag) begin
         done_flag = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      end
      $finish;
   end

   initial begin
      int wcnt;
      void'($urandom(32'd2718));
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 mode", int'(mode), 3);
      chk("R1 cpu_rst", int'(cpu_rst), 1);
      chk("R1 vdd_sw_en", int'(vdd_sw_en), 1);
      chk("R1 wake", int'(wake), 1);
      chk("R1 xram_invalid", int'(xram_invalid), 1);
      chk("R1 sleep_pending", int'(sleep_pending), 0);
      chk("R1 clears", int'(vol_clr | nv_clr), 0);
      m_mode = 3; m_cnt = 0; m_pend = 0; m_xinv = 1; m_vclr = 0; m_nclr = 0;
      rst_n = 1;

      // R6/R7 power-up waking length and target with main present
      wcnt = 0;
      while (m_mode == 3 && wcnt < 100) begin
         wcnt++;
         step();
      end
      chk("R6 waking length", wcnt, RSTC);
      chk("R7 target mission", int'(mode), 0);

      // R2 wrong address ignored
      wr_en = 1; wr_addr = SADDR + 16'd1; wr_data = 8'h80;
      step();
      chk("R2 other addr", int'(sleep_pending), 0);
      // R2 set request
      wr_addr = SADDR; wr_data = 8'h80;
      step();
      chk("R2 request set", int'(sleep_pending), 1);
      quiet();
      step();
      chk("R3 entered sleep", int'(mode), 2);
      chk("R3 supply off", int'(vdd_sw_en), 0);
      chk("R3 request cleared", int'(sleep_pending), 0);
      step();
      chk("R5 one-cycle sleep", int'(mode), 3);
      chk("R9 vol_clr pulse", int'(vol_clr), 1);
      chk("R9 nv_clr quiet", int'(nv_clr), 0);
      chk("R10 xram flagged", int'(xram_invalid), 1);
      while (m_mode == 3) step();
      chk("R7 back to mission", int'(mode), 0);

      // R10 write acknowledges xram
      wr_en = 1; wr_addr = SADDR; wr_data = 8'h00;
      step();
      chk("R10 xram cleared", int'(xram_invalid), 0);
      quiet();

      // R8 brownout then sleep on battery
      main_pwr_ok = 0;
      step();
      chk("R8 to brownout", int'(mode), 1);
      wr_en = 1; wr_addr = SADDR; wr_data = 8'h80;
      step();
      quiet();
      step();
      chk("R3 sleep from brownout", int'(mode), 2);
      repeat (20) step();
      chk("R4 stays asleep", int'(mode), 2);
      wr_en = 1; wr_addr = SADDR; wr_data = 8'hFF;
      step();
      chk("R2 write ignored in sleep", int'(sleep_pending), 0);
      quiet();
      ext_reset = 1; wake_evt = 4'b0100;
      step();
      chk("R5 wake event", int'(mode), 3);
      chk("R9 nv_clr with ext reset", int'(nv_clr), 1);
      quiet(); ext_reset = 0;
      while (m_mode == 3) step();
      chk("R7 target brownout", int'(mode), 1);
      main_pwr_ok = 1;
      step();
      chk("R8 to mission", int'(mode), 0);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         wr_en = ($urandom % 8) == 0;
         wr_addr = ($urandom % 2) ? SADDR : 16'($urandom);
         wr_data = 8'($urandom);
         if (($urandom % 16) == 0) main_pwr_ok = ~main_pwr_ok;
         wake_evt = (($urandom % 6) == 0) ? 4'($urandom) : 4'd0;
         ext_reset = 1'($urandom);
         step();
      end

      if (!done_flag) begin
         done_flag = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      end
      $finish;
   end
endmodule